// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel NOR-style flash bus. It works out whether an embedded program or erase inside the flash has finished. It does not wait for a ready pin. Instead it runs pairs of read cycles at one latched address and compares the status bits of the two reads. Bit 6 of the data bus alternates on every read while the device is working. Bit 2 alternates only when the polled address lies in a sector that is being erased or whose erase is suspended.

Software, or a command sequencer, issues the program or erase command first. It then pulses `start` with the address to poll, the strobe mode and a limit on read pairs. The poller drives the chip enable and output enable lines (both active low) and the address. Every spacing on the bus is a whole number of clock cycles, obtained by rounding a nanosecond limit up by the clock-period parameter. The poller finishes with a one-cycle `result_valid` pulse together with one sticky flag: `done` (the second read returned array data), `suspended` (the polled sector's erase is paused), or `timeout`.

Top module: `toggle_poll_engine`

## Requirements
- R1: While reset is asserted and afterwards until the first accepted start, `flash_ce_n` and `flash_oe_n` are high, `flash_addr` is zero, and `busy`, `result_valid`, `done`, `suspended` and `timeout` are low.
- R2: A `start` seen while idle latches `poll_addr`, `strobe_sel` and `pair_limit`. `flash_addr` then holds the latched address until the next accepted start. A `start` seen while `busy` is high has no effect.
- R3: After an accepted start, `busy` rises on the next cycle. The first ceil(T_ASO_NS/CLK_PERIOD_NS) busy cycles are address setup: the strobe line is high and the other line is low. No read is in progress during setup.
- R4: Each read holds both lines low for ceil(T_RD_NS/CLK_PERIOD_NS) cycles. The data bus is sampled on the clock edge that ends this window.
- R5: Between the two reads of a pair, the strobe line stays high for the mode's high time, rounded up to whole cycles. Between pairs there is one evaluation cycle, followed by that same high time.
- R6: With `strobe_sel`=0 the output enable line is pulsed and chip enable stays low for the whole poll. With `strobe_sel`=1 chip enable is pulsed and output enable stays low.
- R7: If bit 6 differs between the two reads of a pair, and the pair limit is not yet used up, a new pair starts.
- R8: If bit 6 is equal and bit 2 is equal in a pair, the result is `done`, and `rd_data` returns the second read's byte.
- R9: If bit 6 is equal and bit 2 differs in a pair, the result is `suspended`, and `rd_data` returns the second read's byte.
- R10: If bit 6 differs in the pair that brings the pair count to `pair_limit`, the result is `timeout`. A limit of 0 behaves as 1.
- R11: `result_valid` is a single-cycle pulse in the first idle cycle after evaluation, with `busy` low. At most one of `done`/`suspended`/`timeout` is set. The flag holds until the next accepted start, which clears it.
- R12: Whenever `busy` is low, both `flash_ce_n` and `flash_oe_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a poll (accepted only when idle) |
| poll_addr | input | ADDR_W | Address to read during polling |
| strobe_sel | input | 1 | 0: pulse output enable; 1: pulse chip enable |
| pair_limit | input | PAIR_W | Maximum read pairs before timeout (0 acts as 1) |
| flash_dq | input | DQ_W | Flash data bus |
| flash_addr | output | ADDR_W | Flash address bus |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| busy | output | 1 | Poll in progress |
| result_valid | output | 1 | One-cycle pulse when a result is posted |
| done | output | 1 | Embedded operation finished |
| suspended | output | 1 | Polled sector is erase-suspended |
| timeout | output | 1 | Toggling did not stop within the pair limit |
| rd_data | output | DQ_W | Second read byte of the final pair |

## Verification
A wrong sequencer state shows up on the pins in the same cycle, because both strobe lines are decoded straight from the state register. A wrong read or high-time length moves every later edge, so the per-cycle comparison catches it at the first misplaced edge. A wrong pair count or a wrong capture register changes nothing until the evaluation cycle. It then shows as a different flag or `rd_data` value, or as one pair too many or too few, at the `result_valid` pulse. Runs whose pass condition depends on a single pair (limit 0, immediate completion) expose errors at the earliest possible evaluation.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;

   typedef enum logic [2:0] {
      PS_IDLE,
      PS_SETUP,
      PS_LOW,
      PS_HIGH,
      PS_EVAL
   } poll_state_e;

   // Round a nanosecond limit up to whole clock cycles, never below one.
   function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned per);
      int unsigned c;
      c = (ns + per - 1) / per;
      if (c == 0) c = 1;
      return c;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tpoll_timer.sv
module tpoll_timer #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/tpoll_pair_ctr.sv
module tpoll_pair_ctr #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] limit,
   output logic         last
);
   localparam logic [W:0] ONE_X = (W+1)'(1);

   logic [W-1:0] cnt_q;
   logic [W-1:0] eff_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc) begin
         cnt_q <= cnt_q + W'(1);
      end
   end

   // A zero limit still allows one pair.
   assign eff_limit = (limit == '0) ? W'(1) : limit;
   assign last      = (({1'b0, cnt_q} + ONE_X) >= {1'b0, eff_limit});
endmodule

// File: rtl/tpoll_cmp.sv
module tpoll_cmp (
   input  logic [1:0] st_a,
   input  logic [1:0] st_b,
   output logic       tgl_main,
   output logic       tgl_sector
);
   // Bit 1 carries the busy-toggle bit, bit 0 the sector-toggle bit.
   logic [1:0] diff;

   for (genvar i = 0; i < 2; i++) begin : g_diff
      assign diff[i] = st_a[i] ^ st_b[i];
   end

   assign tgl_main   = diff[1];
   assign tgl_sector = diff[0];
endmodule

// File: rtl/toggle_poll_engine.sv
module toggle_poll_engine
   import tpoll_pkg::*;
#(
   parameter int unsigned ADDR_W        = 26,
   parameter int unsigned DQ_W          = 8,
   parameter int unsigned TGL_BIT       = 6,
   parameter int unsigned ERS_BIT       = 2,
   parameter int unsigned PAIR_W        = 16,
   parameter int unsigned CLK_PERIOD_NS = 10,
   parameter int unsigned T_ASO_NS      = 15,
   parameter int unsigned T_CEPH_NS     = 20,
   parameter int unsigned T_OEPH_NS     = 20,
   parameter int unsigned T_RD_NS       = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] poll_addr,
   input  logic              strobe_sel,
   input  logic [PAIR_W-1:0] pair_limit,
   input  logic [DQ_W-1:0]   flash_dq,
   output logic [ADDR_W-1:0] flash_addr,
   output logic              flash_ce_n,
   output logic              flash_oe_n,
   output logic              busy,
   output logic              result_valid,
   output logic              done,
   output logic              suspended,
   output logic              timeout,
   output logic [DQ_W-1:0]   rd_data
);
   localparam int unsigned C_ASO = ns_to_cycles(T_ASO_NS,  CLK_PERIOD_NS);
   localparam int unsigned C_HCE = ns_to_cycles(T_CEPH_NS, CLK_PERIOD_NS);
   localparam int unsigned C_HOE = ns_to_cycles(T_OEPH_NS, CLK_PERIOD_NS);
   localparam int unsigned C_RD  = ns_to_cycles(T_RD_NS,   CLK_PERIOD_NS);
   localparam int unsigned C_MAX = max2(max2(C_ASO, C_RD), max2(C_HCE, C_HOE));
   localparam int unsigned CNT_W = (C_MAX <= 1) ? 1 : $clog2(C_MAX);

   localparam logic [CNT_W-1:0] LD_ASO = CNT_W'(C_ASO - 1);
   localparam logic [CNT_W-1:0] LD_RD  = CNT_W'(C_RD - 1);
   localparam logic [CNT_W-1:0] LD_HCE = CNT_W'(C_HCE - 1);
   localparam logic [CNT_W-1:0] LD_HOE = CNT_W'(C_HOE - 1);

   // Elaboration-time parameter checks
   if (TGL_BIT >= DQ_W || ERS_BIT >= DQ_W) begin : g_bad_bitpos
      $error("status bit positions must lie inside the data bus");
   end
   if (TGL_BIT == ERS_BIT) begin : g_bad_bitsame
      $error("busy-toggle and sector-toggle bits must differ");
   end
   if (ADDR_W < 1 || PAIR_W < 1 || DQ_W < 2) begin : g_bad_width
      $error("address, pair-count and data widths are too small");
   end
   if (CLK_PERIOD_NS < 1) begin : g_bad_period
      $error("clock period must be at least 1 ns");
   end

   poll_state_e st_q, st_d;
   logic              ph_q, ph_d;           // 0: first read of pair, 1: second
   logic              sel_q;
   logic [ADDR_W-1:0] addr_q;
   logic [PAIR_W-1:0] limit_q;
   logic [1:0]        first_q;
   logic [DQ_W-1:0]   second_q;
   logic              rv_q, done_q, susp_q, tmo_q;
   logic [DQ_W-1:0]   data_q;

   logic              tmr_load, tmr_exp;
   logic [CNT_W-1:0]  tmr_val;
   logic [CNT_W-1:0]  ld_high;
   logic              accept, cap_first, cap_second;
   logic              pr_clr, pr_inc, pr_last;
   logic              fin, fin_done, fin_susp, fin_tmo;
   logic              tgl_main, tgl_sector;

   // High time between reads depends on which line is pulsed.
   if (C_HCE == C_HOE) begin : g_high_same
      assign ld_high = LD_HOE;
   end else begin : g_high_mode
      assign ld_high = sel_q ? LD_HCE : LD_HOE;
   end

   tpoll_timer #(.W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   tpoll_pair_ctr #(.W(PAIR_W)) u_pairs (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (pr_clr),
      .inc   (pr_inc),
      .limit (limit_q),
      .last  (pr_last)
   );

   tpoll_cmp u_cmp (
      .st_a       (first_q),
      .st_b       ({second_q[TGL_BIT], second_q[ERS_BIT]}),
      .tgl_main   (tgl_main),
      .tgl_sector (tgl_sector)
   );

   always_comb begin
      st_d       = st_q;
      ph_d       = ph_q;
      tmr_load   = 1'b0;
      tmr_val    = '0;
      accept     = 1'b0;
      cap_first  = 1'b0;
      cap_second = 1'b0;
      pr_clr     = 1'b0;
      pr_inc     = 1'b0;
      fin        = 1'b0;
      fin_done   = 1'b0;
      fin_susp   = 1'b0;
      fin_tmo    = 1'b0;
      unique case (st_q)
         PS_IDLE: begin
            if (start) begin
               accept   = 1'b1;
               pr_clr   = 1'b1;
               ph_d     = 1'b0;
               tmr_load = 1'b1;
               tmr_val  = LD_ASO;
               st_d     = PS_SETUP;
            end
         end
         PS_SETUP: begin
            if (tmr_exp) begin
               tmr_load = 1'b1;
               tmr_val  = LD_RD;
               st_d     = PS_LOW;
            end
         end
         PS_LOW: begin
            if (tmr_exp) begin
               if (!ph_q) begin
                  cap_first = 1'b1;
                  ph_d      = 1'b1;
                  tmr_load  = 1'b1;
                  tmr_val   = ld_high;
                  st_d      = PS_HIGH;
               end else begin
                  cap_second = 1'b1;
                  st_d       = PS_EVAL;
               end
            end
         end
         PS_HIGH: begin
            if (tmr_exp) begin
               tmr_load = 1'b1;
               tmr_val  = LD_RD;
               st_d     = PS_LOW;
            end
         end
         PS_EVAL: begin
            if (!tgl_main) begin
               fin      = 1'b1;
               fin_susp = tgl_sector;
               fin_done = !tgl_sector;
               st_d     = PS_IDLE;
            end else if (pr_last) begin
               fin     = 1'b1;
               fin_tmo = 1'b1;
               st_d    = PS_IDLE;
            end else begin
               pr_inc   = 1'b1;
               ph_d     = 1'b0;
               tmr_load = 1'b1;
               tmr_val  = ld_high;
               st_d     = PS_HIGH;
            end
         end
         default: st_d = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= PS_IDLE;
         ph_q    <= 1'b0;
         sel_q   <= 1'b0;
         addr_q  <= '0;
         limit_q <= '0;
      end else begin
         st_q <= st_d;
         ph_q <= ph_d;
         if (accept) begin
            sel_q   <= strobe_sel;
            addr_q  <= poll_addr;
            limit_q <= pair_limit;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q  <= '0;
         second_q <= '0;
      end else begin
         if (cap_first)  first_q  <= {flash_dq[TGL_BIT], flash_dq[ERS_BIT]};
         if (cap_second) second_q <= flash_dq;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rv_q   <= 1'b0;
         done_q <= 1'b0;
         susp_q <= 1'b0;
         tmo_q  <= 1'b0;
         data_q <= '0;
      end else begin
         rv_q <= fin;
         if (accept) begin
            done_q <= 1'b0;
            susp_q <= 1'b0;
            tmo_q  <= 1'b0;
         end else if (fin) begin
            done_q <= fin_done;
            susp_q <= fin_susp;
            tmo_q  <= fin_tmo;
            data_q <= second_q;
         end
      end
   end

   // Pin decode: the pulsed line falls only in read windows, the other
   // line is held low for the whole poll.
   logic active, strobe_n, hold_n;
   assign active   = (st_q != PS_IDLE);
   assign strobe_n = (st_q != PS_LOW);
   assign hold_n   = !active;

   assign flash_ce_n   = sel_q ? strobe_n : hold_n;
   assign flash_oe_n   = sel_q ? hold_n   : strobe_n;
   assign flash_addr   = addr_q;
   assign busy         = active;
   assign result_valid = rv_q;
   assign done         = done_q;
   assign suspended    = susp_q;
   assign timeout      = tmo_q;
   assign rd_data      = data_q;
endmodule

// File: rtl/tpoll_checker.sv
module tpoll_checker #(
   parameter int unsigned ADDR_W = 26
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              result_valid,
   input logic              done,
   input logic              suspended,
   input logic              timeout,
   input logic              flash_ce_n,
   input logic              flash_oe_n,
   input logic [ADDR_W-1:0] flash_addr
);
   assert_idle_lines_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (flash_ce_n && flash_oe_n));

   assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(flash_addr));

   assert_setup_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (flash_ce_n || flash_oe_n));

   assert_one_line_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(flash_ce_n && flash_oe_n));

   assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);

   assert_pulse_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> !busy);

   assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, suspended, timeout}));

   assert_flags_clear_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(done || suspended || timeout));

   assert_flag_with_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> $countones({done, suspended, timeout}) == 1);
endmodule

bind toggle_poll_engine tpoll_checker #(.ADDR_W(ADDR_W)) u_tpoll_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .result_valid (result_valid),
   .done         (done),
   .suspended    (suspended),
   .timeout      (timeout),
   .flash_ce_n   (flash_ce_n),
   .flash_oe_n   (flash_oe_n),
   .flash_addr   (flash_addr)
);

// File: tb/test_toggle_poll_engine.sv
module test_toggle_poll_engine;
   localparam int PER  = 8;
   localparam int AW   = 26;
   localparam int PW   = 16;
   localparam int ASO  = 15;
   localparam int RDNS = 40;
   localparam int OEPH = 20;
   localparam int CEPH = 28;

   function automatic int cyc(input int ns);
      int c;
      c = (ns + PER - 1) / PER;
      return (c < 1) ? 1 : c;
   endfunction

   localparam int N_ASO = cyc(ASO);
   localparam int N_RD  = cyc(RDNS);
   localparam int N_HOE = cyc(OEPH);
   localparam int N_HCE = cyc(CEPH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] poll_addr = '0;
   logic          strobe_sel = 1'b0;
   logic [PW-1:0] pair_limit = '0;
   logic [7:0]    flash_dq;
   logic [AW-1:0] flash_addr;
   logic          flash_ce_n, flash_oe_n, busy, result_valid, done, suspended, timeout;
   logic [7:0]    rd_data;

   always #4 clk = ~clk;

   toggle_poll_engine #(
      .ADDR_W(AW), .DQ_W(8), .TGL_BIT(6), .ERS_BIT(2), .PAIR_W(PW),
      .CLK_PERIOD_NS(PER), .T_ASO_NS(ASO), .T_CEPH_NS(CEPH),
      .T_OEPH_NS(OEPH), .T_RD_NS(RDNS)
   ) i_toggle_poll_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .poll_addr(poll_addr),
      .strobe_sel(strobe_sel), .pair_limit(pair_limit), .flash_dq(flash_dq),
      .flash_addr(flash_addr), .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
      .busy(busy), .result_valid(result_valid), .done(done),
      .suspended(suspended), .timeout(timeout), .rd_data(rd_data)
   );

   // ---------------- behavioural flash ----------------
   int         rd_cnt = 0;
   int         rd_base = 0;
   int         sc_n = 0;
   bit         sc_susp = 0;
   bit         sc_insec = 0;
   logic [7:0] sc_data = 8'h00;
   bit         prev_act = 0;

   // Reads 0..sc_n-1 are busy status (bit 6 alternates, bit 2 alternates when
   // the sector is being erased); later reads are suspend status (bit 6 fixed,
   // bit 2 alternates) or constant array data.
   function automatic logic [7:0] flash_byte(input int idx);
      logic [7:0] b;
      bit par;
      par = (idx % 2) != 0;
      if (idx < sc_n) begin
         b = 8'h08;
         b[6] = par;
         b[2] = sc_insec & par;
      end else if (sc_susp) begin
         b = 8'h80;
         b[2] = par;
      end else begin
         b = sc_data;
      end
      return b;
   endfunction

   assign flash_dq = flash_byte(rd_cnt - rd_base);

   always @(negedge clk) begin
      bit act;
      act = !flash_ce_n && !flash_oe_n;
      if (prev_act && !act) rd_cnt = rd_cnt + 1;
      prev_act = act;
   end

   // ---------------- reference model ----------------
   typedef struct packed {
      logic       ce_n;
      logic       oe_n;
      logic       busy;
      logic       rv;
      logic       done;
      logic       susp;
      logic       tmo;
      logic [7:0] data;
   } exp_t;

   exp_t          q[$];
   exp_t          last_e = '{ce_n:1'b1, oe_n:1'b1, default:'0};
   logic [AW-1:0] exp_addr = '0;
   int            vectors = 0;
   int            fails = 0;
   int            cycle = 0;

   task automatic push_n(input int n, input logic ce, input logic oe);
      for (int i = 0; i < n; i++) q.push_back('{ce_n:ce, oe_n:oe, busy:1'b1, default:'0});
   endtask

   task automatic check(input string tag);
      exp_t e;
      bit bad;
      bad = 0;
      if (q.size() > 0) begin
         e = q.pop_front();
         last_e = e;
      end else begin
         e = last_e;
         e.rv = 1'b0; e.busy = 1'b0; e.ce_n = 1'b1; e.oe_n = 1'b1;
      end
      vectors++;
      if (flash_ce_n !== e.ce_n || flash_oe_n !== e.oe_n) begin
         bad = 1;
         $display("FAIL %s R4 R5 R6 R12 cycle %0d ce_n/oe_n=%b%b expected %b%b",
                  tag, cycle, flash_ce_n, flash_oe_n, e.ce_n, e.oe_n);
      end
      if (busy !== e.busy) begin
         bad = 1;
         $display("FAIL %s R3 cycle %0d busy=%b expected %b", tag, cycle, busy, e.busy);
      end
      if (flash_addr !== exp_addr) begin
         bad = 1;
         $display("FAIL %s R2 cycle %0d flash_addr=%h expected %h", tag, cycle, flash_addr, exp_addr);
      end
      if (result_valid !== e.rv) begin
         bad = 1;
         $display("FAIL %s R11 cycle %0d result_valid=%b expected %b", tag, cycle, result_valid, e.rv);
      end
      if (done !== e.done) begin
         bad = 1;
         $display("FAIL %s R8 cycle %0d done=%b expected %b", tag, cycle, done, e.done);
      end
      if (suspended !== e.susp) begin
         bad = 1;
         $display("FAIL %s R9 cycle %0d suspended=%b expected %b", tag, cycle, suspended, e.susp);
      end
      if (timeout !== e.tmo) begin
         bad = 1;
         $display("FAIL %s R10 cycle %0d timeout=%b expected %b", tag, cycle, timeout, e.tmo);
      end
      if (e.rv && rd_data !== e.data) begin
         bad = 1;
         $display("FAIL %s R8 R9 cycle %0d rd_data=%h expected %h", tag, cycle, rd_data, e.data);
      end
      if (bad) fails++;
   endtask

   task automatic tick(input string tag);
      @(negedge clk);
      cycle++;
      check(tag);
   endtask

   // One complete poll. ign_at > 0 re-pulses start (with other inputs) at that
   // cycle of the run to show it is ignored while busy (R2).
   task automatic run_poll(input string tag, input logic [AW-1:0] addr, input logic sel,
                           input int limit, input int n, input bit susp, input bit insec,
                           input logic [7:0] data, input int ign_at);
      logic hce, hoe;   // line levels between reads
      int hi, eff, k;
      logic [7:0] a, b;
      exp_t r;
      sc_n = n; sc_susp = susp; sc_insec = insec; sc_data = data;
      rd_base = rd_cnt;
      hce = sel ? 1'b1 : 1'b0;
      hoe = sel ? 1'b0 : 1'b1;
      hi  = sel ? N_HCE : N_HOE;
      eff = (limit == 0) ? 1 : limit;
      poll_addr = addr; strobe_sel = sel; pair_limit = PW'(limit); start = 1'b1;
      exp_addr = addr;
      push_n(N_ASO, hce, hoe);                          // R3 setup
      k = 0;
      r = '{ce_n:1'b1, oe_n:1'b1, rv:1'b1, default:'0};
      forever begin
         if (k > 0) push_n(hi, hce, hoe);               // R5 after evaluation
         push_n(N_RD, 1'b0, 1'b0);                      // R4 first read
         push_n(hi, hce, hoe);                          // R5 mid-pair
         push_n(N_RD, 1'b0, 1'b0);                      // R4 second read
         push_n(1, hce, hoe);                           // evaluation cycle
         a = flash_byte(2 * k);
         b = flash_byte(2 * k + 1);
         r.data = b;
         if (a[6] == b[6]) begin
            if (a[2] != b[2]) r.susp = 1'b1;            // R9
            else r.done = 1'b1;                         // R8
            break;
         end else if (k + 1 >= eff) begin
            r.tmo = 1'b1;                               // R10
            break;
         end
         k++;                                           // R7 keep polling
      end
      q.push_back(r);
      tick(tag);
      start = 1'b0;
      poll_addr = ~addr; strobe_sel = ~sel; pair_limit = '1;
      for (int c = 1; q.size() > 0; c++) begin
         if (c == ign_at) start = 1'b1;
         tick(tag);
         start = 1'b0;
      end
      repeat (3) tick(tag);
   endtask

   initial begin
      repeat (3) tick("R1 reset");
      rst_n = 1'b1;
      repeat (2) tick("R1 idle");
      // R8 completion on the first pair, output-enable strobing
      run_poll("R8 oe immediate", 26'h0012345, 1'b0, 4, 0, 0, 0, 8'h5A, 0);
      // R7 R8 three pairs, sector erasing, ignored start mid-run (R2)
      run_poll("R7 oe toggling", 26'h1ABCDEF, 1'b0, 10, 4, 0, 1, 8'hC3, 9);
      // R6 chip-enable strobing with longer high time
      run_poll("R6 ce toggling", 26'h0000F00, 1'b1, 8, 6, 0, 0, 8'h3C, 20);
      // R9 erase suspended in the polled sector
      run_poll("R9 ce suspend", 26'h2000000, 1'b1, 5, 2, 1, 1, 8'h00, 0);
      // R9 suspend status on the very first pair, output-enable strobing
      run_poll("R9 oe suspend", 26'h3FFFFFF, 1'b0, 1, 0, 1, 0, 8'h00, 0);
      // R10 timeout after three pairs
      run_poll("R10 limit", 26'h0A0A0A0, 1'b0, 3, 100, 0, 1, 8'hFF, 0);
      // R10 limit zero acts as one pair
      run_poll("R10 zero", 26'h0505050, 1'b1, 0, 100, 0, 0, 8'hFF, 0);
      // R11 a fresh start clears the previous flag
      run_poll("R11 restart", 26'h0000001, 1'b0, 2, 2, 0, 0, 8'h81, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(PER * 150000);
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cycle);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule